// File: doc/BRIEF.md
# Flash Command Interface Decoder

This block sits between a byte-wide host bus and the write machinery of a flash memory. It turns host write strobes into commands. Single-cycle codes change what a host read returns: array contents, identifier bytes or a status byte. They can also clear error flags or pause and restart an erase. Two-cycle codes arm a byte program or a block erase. The cycle that follows supplies the target and, for an erase, a confirm code.

Accepted operations leave the block as one-cycle request pulses with their address, data or block index. A write state machine outside the block carries them out. That machine reports back through a busy level, an end-of-erase pulse and two failure pulses. The block keeps a status byte built from these reports and from its own sequence checking. Once a program, an erase or a suspend is accepted, host reads return that status byte with no further command.

Top module: `flash_cmd_decoder`

## Requirements
- R1: After synchronous reset, `rdata` is 0, no request output is high, reads return array data, and status bits 6 to 0 are zero.
- R2: A read (`rd_en` high at an edge) updates `rdata` at that edge. In array selection, `rdata` takes the `array_data` value sampled at that edge. Writing FFh while idle selects array data. Writing FFh as the cycle after the erase code 20h also selects array data, cancels the erase and flags no error.
- R3: Writing 90h selects identifier output. Reads then alternate between `MFR_ID` and `DEV_ID`, starting with `MFR_ID`. A new 90h restarts the alternation at `MFR_ID`.
- R4: Writing 70h selects status output. The status byte holds these bits: bit 7 is the inverse of `wsm_busy` at the read edge, bit 6 is erase-suspended, bit 5 is erase failure, bit 4 is program failure, bit 3 is sequence error, and bits 2 to 0 are zero.
- R5: Bits 5, 4 and 3 are sticky; each is set by its own event. Writing 50h while idle clears those three bits, leaves bit 6 untouched and does not change the read selection.
- R6: Writing 40h or 10h while idle arms a program. The next write, whatever its data (FFh and D0h included), produces a one-cycle `prog_req`. `prog_addr` and `prog_data` come from that write, and status output is selected.
- R7: Writing 20h and then D0h produces a one-cycle `erase_req`. `erase_blk` is the top `BLK_W` bits of the second write's address, status output is selected and an erase becomes in progress.
- R8: If the write after 20h carries any code other than D0h or FFh, no erase request is made. Status bit 3 is set, status output is selected and the next write is decoded as a new command.
- R9: Writing B0h while an erase is in progress and not suspended produces a one-cycle `susp_req`, sets status bit 6 and selects status output. In any other state B0h changes nothing.
- R10: Writing D0h while idle and suspended produces a one-cycle `resume_req` and clears bit 6, and the read selection is unchanged. D0h changes nothing when the block is not suspended. An `erase_done` pulse ends the erase in progress and clears bit 6.
- R11: While idle, any code not listed above is ignored: no request is made and the read selection is unchanged.
- R12: At most one of `prog_req`, `erase_req`, `susp_req` and `resume_req` is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Host write strobe, one cycle per bus write |
| addr | input | ADDR_W | Host address for the write |
| wdata | input | 8 | Host write data or command code |
| rd_en | input | 1 | Host read strobe |
| array_data | input | 8 | Byte read from the memory array |
| rdata | output | 8 | Registered host read data |
| wsm_busy | input | 1 | Write machine busy level |
| erase_done | input | 1 | Pulse: erase has finished |
| prog_fail | input | 1 | Pulse: program failed |
| erase_fail | input | 1 | Pulse: erase failed |
| prog_req | output | 1 | One-cycle program request |
| prog_addr | output | ADDR_W | Program target address |
| prog_data | output | 8 | Program data byte |
| erase_req | output | 1 | One-cycle block erase request |
| erase_blk | output | BLK_W | Block index to erase |
| susp_req | output | 1 | One-cycle erase suspend request |
| resume_req | output | 1 | One-cycle erase resume request |

## Verification
The hardest state to reach is a suspended erase. It needs an accepted erase that is still in progress, then B0h, all before any `erase_done` pulse arrives. Only in that window are the resume path and the "clear keeps bit 6" rule visible. Directed steps build that window on purpose and then check that a second B0h, a second D0h and a late B0h have no effect. A long seeded random run then mixes commands, reads, failure pulses, busy changes and end-of-erase pulses. A bench model tracks the same state and predicts every request and every read.

// File: rtl/fcd_pkg.sv
package fcd_pkg;

  typedef enum logic [1:0] {
    RD_ARRAY  = 2'd0,
    RD_IDENT  = 2'd1,
    RD_STATUS = 2'd2
  } rd_sel_t;

  typedef enum logic [1:0] {
    SQ_IDLE  = 2'd0,
    SQ_PROG  = 2'd1,
    SQ_ERASE = 2'd2
  } seq_t;

  // command codes are fixed by the bus protocol
  localparam logic [7:0] C_READ    = 8'hFF;
  localparam logic [7:0] C_IDENT   = 8'h90;
  localparam logic [7:0] C_STAT    = 8'h70;
  localparam logic [7:0] C_CLR     = 8'h50;
  localparam logic [7:0] C_PROG_A  = 8'h40;
  localparam logic [7:0] C_PROG_B  = 8'h10;
  localparam logic [7:0] C_ERASE   = 8'h20;
  localparam logic [7:0] C_SUSP    = 8'hB0;
  localparam logic [7:0] C_CONFIRM = 8'hD0;

  localparam int NUM_STICKY = 3;  // bits 3..5 of the status byte

endpackage

// File: rtl/fcd_seq.sv
module fcd_seq
  import fcd_pkg::*;
#(
  parameter int ADDR_W = 19,
  parameter int BLK_W  = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        wdata,
  input  logic              erase_done,
  output rd_sel_t           rd_sel,
  output logic              ident_restart,
  output logic              clr_evt,
  output logic              seqerr_evt,
  output logic              suspended,
  output logic              prog_req,
  output logic [ADDR_W-1:0] prog_addr,
  output logic [7:0]        prog_data,
  output logic              erase_req,
  output logic [BLK_W-1:0]  erase_blk,
  output logic              susp_req,
  output logic              resume_req
);

  localparam int BLK_LSB = ADDR_W - BLK_W;

  seq_t    state, state_nx;
  rd_sel_t sel_nx;
  logic    erasing, erasing_nx, susp_nx;
  logic    prog_go, erase_go, susp_go, resume_go;

  always_comb begin
    state_nx      = state;
    sel_nx        = rd_sel;
    erasing_nx    = erasing;
    susp_nx       = suspended;
    prog_go       = 1'b0;
    erase_go      = 1'b0;
    susp_go       = 1'b0;
    resume_go     = 1'b0;
    ident_restart = 1'b0;
    clr_evt       = 1'b0;
    seqerr_evt    = 1'b0;
    if (wr_en) begin
      case (state)
        SQ_PROG: begin  // R6: any byte is data
          prog_go  = 1'b1;
          sel_nx   = RD_STATUS;
          state_nx = SQ_IDLE;
        end
        SQ_ERASE: begin
          state_nx = SQ_IDLE;
          if (wdata == C_CONFIRM) begin  // R7
            erase_go   = 1'b1;
            erasing_nx = 1'b1;
            sel_nx     = RD_STATUS;
          end else if (wdata == C_READ) begin  // R2: cancel quietly
            sel_nx = RD_ARRAY;
          end else begin  // R8
            seqerr_evt = 1'b1;
            sel_nx     = RD_STATUS;
          end
        end
        default: begin
          case (wdata)
            C_READ:  sel_nx = RD_ARRAY;
            C_IDENT: begin
              sel_nx        = RD_IDENT;
              ident_restart = 1'b1;
            end
            C_STAT:  sel_nx = RD_STATUS;
            C_CLR:   clr_evt = 1'b1;
            C_PROG_A, C_PROG_B: state_nx = SQ_PROG;
            C_ERASE: state_nx = SQ_ERASE;
            C_SUSP: begin  // R9
              if (erasing && !suspended) begin
                susp_go = 1'b1;
                susp_nx = 1'b1;
                sel_nx  = RD_STATUS;
              end
            end
            C_CONFIRM: begin  // R10
              if (suspended) begin
                resume_go = 1'b1;
                susp_nx   = 1'b0;
              end
            end
            default: ;  // R11
          endcase
        end
      endcase
    end
    if (erase_done) begin
      erasing_nx = 1'b0;
      susp_nx    = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= SQ_IDLE;
      rd_sel     <= RD_ARRAY;
      erasing    <= 1'b0;
      suspended  <= 1'b0;
      prog_req   <= 1'b0;
      erase_req  <= 1'b0;
      susp_req   <= 1'b0;
      resume_req <= 1'b0;
      prog_addr  <= '0;
      prog_data  <= '0;
      erase_blk  <= '0;
    end else begin
      state      <= state_nx;
      rd_sel     <= sel_nx;
      erasing    <= erasing_nx;
      suspended  <= susp_nx;
      prog_req   <= prog_go;
      erase_req  <= erase_go;
      susp_req   <= susp_go;
      resume_req <= resume_go;
      if (prog_go) begin
        prog_addr <= addr;
        prog_data <= wdata;
      end
      if (erase_go) erase_blk <= addr[ADDR_W-1:BLK_LSB];
    end
  end

endmodule

// File: rtl/fcd_status.sv
module fcd_status
  import fcd_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       clr_evt,
  input  logic       seqerr_evt,
  input  logic       prog_fail,
  input  logic       erase_fail,
  input  logic       suspended,
  input  logic       wsm_busy,
  output logic [7:0] status
);

  logic [NUM_STICKY-1:0] set_v;
  logic [NUM_STICKY-1:0] sticky;

  // order gives bit 3 = sequence, bit 4 = program, bit 5 = erase (R4)
  assign set_v = {erase_fail, prog_fail, seqerr_evt};

  always_ff @(posedge clk) begin
    if (rst) begin
      sticky <= '0;
    end else begin
      for (int i = 0; i < NUM_STICKY; i++) begin
        if (set_v[i])     sticky[i] <= 1'b1;  // R5: a new event wins
        else if (clr_evt) sticky[i] <= 1'b0;
      end
    end
  end

  assign status = {~wsm_busy, suspended, sticky, 3'b000};

endmodule

// File: rtl/fcd_readmux.sv
module fcd_readmux
  import fcd_pkg::*;
#(
  parameter logic [7:0] MFR_ID = 8'h5A,
  parameter logic [7:0] DEV_ID = 8'hC3
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       rd_en,
  input  rd_sel_t    rd_sel,
  input  logic       ident_restart,
  input  logic [7:0] array_data,
  input  logic [7:0] status,
  output logic [7:0] rdata
);

  logic id_second;

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata     <= '0;
      id_second <= 1'b0;
    end else begin
      if (ident_restart)                     id_second <= 1'b0;
      else if (rd_en && rd_sel == RD_IDENT)  id_second <= ~id_second;
      if (rd_en) begin
        case (rd_sel)
          RD_ARRAY: rdata <= array_data;
          RD_IDENT: rdata <= id_second ? DEV_ID : MFR_ID;
          default:  rdata <= status;
        endcase
      end
    end
  end

endmodule

// File: rtl/flash_cmd_decoder.sv
module flash_cmd_decoder
  import fcd_pkg::*;
#(
  parameter int         ADDR_W = 19,
  parameter int         BLK_W  = 3,
  parameter logic [7:0] MFR_ID = 8'h5A,
  parameter logic [7:0] DEV_ID = 8'hC3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        wdata,
  input  logic              rd_en,
  input  logic [7:0]        array_data,
  output logic [7:0]        rdata,
  input  logic              wsm_busy,
  input  logic              erase_done,
  input  logic              prog_fail,
  input  logic              erase_fail,
  output logic              prog_req,
  output logic [ADDR_W-1:0] prog_addr,
  output logic [7:0]        prog_data,
  output logic              erase_req,
  output logic [BLK_W-1:0]  erase_blk,
  output logic              susp_req,
  output logic              resume_req
);

  rd_sel_t    rd_sel;
  logic       ident_restart, clr_evt, seqerr_evt, suspended;
  logic [7:0] status;

  fcd_seq #(.ADDR_W(ADDR_W), .BLK_W(BLK_W)) u_seq (
    .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .erase_done(erase_done), .rd_sel(rd_sel), .ident_restart(ident_restart),
    .clr_evt(clr_evt), .seqerr_evt(seqerr_evt), .suspended(suspended),
    .prog_req(prog_req), .prog_addr(prog_addr), .prog_data(prog_data),
    .erase_req(erase_req), .erase_blk(erase_blk), .susp_req(susp_req),
    .resume_req(resume_req)
  );

  fcd_status u_status (
    .clk(clk), .rst(rst), .clr_evt(clr_evt), .seqerr_evt(seqerr_evt),
    .prog_fail(prog_fail), .erase_fail(erase_fail), .suspended(suspended),
    .wsm_busy(wsm_busy), .status(status)
  );

  fcd_readmux #(.MFR_ID(MFR_ID), .DEV_ID(DEV_ID)) u_rd (
    .clk(clk), .rst(rst), .rd_en(rd_en), .rd_sel(rd_sel),
    .ident_restart(ident_restart), .array_data(array_data),
    .status(status), .rdata(rdata)
  );

endmodule

// File: rtl/fcd_checker.sv
module fcd_checker
  import fcd_pkg::*;
(
  input logic       clk,
  input logic       rst,
  input logic       wr_en,
  input logic [7:0] wdata,
  input logic       rd_en,
  input logic       wsm_busy,
  input logic [7:0] rdata,
  input logic       prog_req,
  input logic       erase_req,
  input logic       susp_req,
  input logic       resume_req,
  input rd_sel_t    rd_sel,
  input logic       suspended,
  input logic [7:0] status
);

  a_r12_one_request: assert property (@(posedge clk) disable iff (rst)
    $onehot0({prog_req, erase_req, susp_req, resume_req}));

  a_r6_prog_after_write: assert property (@(posedge clk) disable iff (rst)
    prog_req |-> $past(wr_en));

  a_r7_erase_confirmed: assert property (@(posedge clk) disable iff (rst)
    erase_req |-> ($past(wr_en) && $past(wdata) == C_CONFIRM));

  a_r4_ready_bit: assert property (@(posedge clk) disable iff (rst)
    (rd_en && rd_sel == RD_STATUS) |=> (rdata[7] == !$past(wsm_busy)));

  a_r10_resume_needs_suspend: assert property (@(posedge clk) disable iff (rst)
    resume_req |-> (!suspended && $past(suspended)));

  a_r5_clear_only_by_cmd: assert property (@(posedge clk) disable iff (rst)
    ($fell(status[3]) && !$past(rst)) |-> ($past(wr_en) && $past(wdata) == C_CLR));

endmodule

bind flash_cmd_decoder fcd_checker u_chk (
  .clk(clk), .rst(rst), .wr_en(wr_en), .wdata(wdata), .rd_en(rd_en),
  .wsm_busy(wsm_busy), .rdata(rdata), .prog_req(prog_req),
  .erase_req(erase_req), .susp_req(susp_req), .resume_req(resume_req),
  .rd_sel(rd_sel), .suspended(suspended), .status(status)
);

// File: tb/flash_cmd_decoder_test.sv
module flash_cmd_decoder_test;

  localparam int         ADDR_W = 19;
  localparam int         BLK_W  = 3;
  localparam logic [7:0] MFR    = 8'h5A;
  localparam logic [7:0] DEV    = 8'hC3;

  logic clk = 1'b0, rst = 1'b1, wr_en = 1'b0, rd_en = 1'b0;
  logic wsm_busy = 1'b0, erase_done = 1'b0, prog_fail = 1'b0, erase_fail = 1'b0;
  logic [ADDR_W-1:0] addr = '0;
  logic [7:0] wdata = '0, array_data = '0;
  logic [7:0] rdata, prog_data;
  logic [ADDR_W-1:0] prog_addr;
  logic [BLK_W-1:0] erase_blk;
  logic prog_req, erase_req, susp_req, resume_req;

  flash_cmd_decoder #(.ADDR_W(ADDR_W), .BLK_W(BLK_W), .MFR_ID(MFR), .DEV_ID(DEV)) uut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .rd_en(rd_en), .array_data(array_data), .rdata(rdata),
    .wsm_busy(wsm_busy), .erase_done(erase_done), .prog_fail(prog_fail),
    .erase_fail(erase_fail), .prog_req(prog_req), .prog_addr(prog_addr),
    .prog_data(prog_data), .erase_req(erase_req), .erase_blk(erase_blk),
    .susp_req(susp_req), .resume_req(resume_req)
  );

  always #4 clk = ~clk;

  int checks = 0, fails = 0;

  // reference model: sel 0 array, 1 ident, 2 status; seq 0 idle, 1 prog, 2 erase
  int m_sel = 0, m_seq = 0;
  bit m_id2 = 0, m_act = 0, m_susp = 0;
  bit [2:0] m_stk = '0;
  bit e_p, e_e, e_s, e_r;
  logic [ADDR_W-1:0] e_pa;
  logic [7:0] e_pd;
  logic [BLK_W-1:0] e_blk;

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic void model_write(logic [ADDR_W-1:0] a, logic [7:0] d);
    e_p = 0; e_e = 0; e_s = 0; e_r = 0;
    if (m_seq == 1) begin
      e_p = 1; e_pa = a; e_pd = d; m_sel = 2; m_seq = 0;
    end else if (m_seq == 2) begin
      m_seq = 0;
      if (d == 8'hD0) begin
        e_e = 1; e_blk = a[ADDR_W-1 -: BLK_W]; m_sel = 2; m_act = 1;
      end else if (d == 8'hFF) m_sel = 0;
      else begin m_stk[0] = 1; m_sel = 2; end
    end else begin
      case (d)
        8'hFF: m_sel = 0;
        8'h90: begin m_sel = 1; m_id2 = 0; end
        8'h70: m_sel = 2;
        8'h50: m_stk = '0;
        8'h40, 8'h10: m_seq = 1;
        8'h20: m_seq = 2;
        8'hB0: if (m_act && !m_susp) begin e_s = 1; m_susp = 1; m_sel = 2; end
        8'hD0: if (m_susp) begin e_r = 1; m_susp = 0; end
        default: ;
      endcase
    end
  endfunction

  task automatic wr(logic [ADDR_W-1:0] a, logic [7:0] d, string req);
    addr = a; wdata = d; wr_en = 1'b1;
    @(posedge clk); #1;
    wr_en = 1'b0;
    model_write(a, d);
    chk(req, {prog_req, erase_req, susp_req, resume_req}, {e_p, e_e, e_s, e_r});
    if (e_p) begin chk(req, prog_addr, e_pa); chk(req, prog_data, e_pd); end
    if (e_e) chk(req, erase_blk, e_blk);
  endtask

  task automatic rd(string req);
    logic [7:0] ad, exp;
    ad = 8'($urandom);
    array_data = ad; rd_en = 1'b1;
    case (m_sel)
      0: exp = ad;
      1: begin exp = m_id2 ? DEV : MFR; m_id2 = !m_id2; end
      default: exp = {~wsm_busy, m_susp, m_stk, 3'b000};
    endcase
    @(posedge clk); #1;
    rd_en = 1'b0;
    chk(req, rdata, exp);
    chk("R12", {prog_req, erase_req, susp_req, resume_req}, 4'b0);
  endtask

  task automatic pulse(int kind);
    case (kind)
      0: begin prog_fail = 1'b1; m_stk[1] = 1; end
      1: begin erase_fail = 1'b1; m_stk[2] = 1; end
      default: begin erase_done = 1'b1; m_act = 0; m_susp = 0; end
    endcase
    @(posedge clk); #1;
    prog_fail = 1'b0; erase_fail = 1'b0; erase_done = 1'b0;
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    #(8 * 150000);
    fails++;
    $display("FAIL watchdog R1..: actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic [7:0] codes [10];
    codes = '{8'hFF, 8'h90, 8'h70, 8'h50, 8'h40, 8'h10, 8'h20, 8'hB0, 8'hD0, 8'h00};
    void'($urandom(32'd2024));
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    // R1: reset state
    chk("R1", rdata, 8'h00);
    chk("R1", {prog_req, erase_req, susp_req, resume_req}, 4'b0);
    rd("R1");
    wr('0, 8'h70, "R1"); rd("R1");
    // R2: array read, FF cancel of armed erase without error
    wr('0, 8'hFF, "R2"); rd("R2");
    wr('0, 8'h20, "R2"); wr(19'h1_0000, 8'hFF, "R2"); rd("R2");
    wr('0, 8'h70, "R2"); rd("R2");
    // R3: identifier alternation and restart
    wr('0, 8'h90, "R3"); rd("R3"); rd("R3"); rd("R3");
    wr('0, 8'h90, "R3"); rd("R3");
    // R4: ready bit follows busy
    wr('0, 8'h70, "R4"); wsm_busy = 1'b1; rd("R4"); wsm_busy = 1'b0; rd("R4");
    // R8: bad confirm
    wr('0, 8'h20, "R8"); wr('0, 8'h33, "R8"); rd("R8");
    wr('0, 8'hFF, "R8"); rd("R8");
    // R7 / R9 / R5 / R10: erase, suspend, clear, resume
    pulse(0); pulse(1);
    wr('0, 8'h20, "R7"); wr(19'h5_1234, 8'hD0, "R7"); rd("R7");
    wr('0, 8'hFF, "R9"); wr('0, 8'hB0, "R9"); rd("R9");
    wr('0, 8'hFF, "R9"); wr('0, 8'hB0, "R9"); rd("R9");
    wr('0, 8'h70, "R5"); wr('0, 8'h50, "R5"); rd("R5");
    wr('0, 8'hD0, "R10"); rd("R10"); wr('0, 8'hD0, "R10"); rd("R10");
    wr('0, 8'hB0, "R9"); pulse(2); wr('0, 8'hB0, "R9"); wr('0, 8'h70, "R10"); rd("R10");
    // R6: program with data that look like commands
    wr('0, 8'h40, "R6"); wr(19'h7_FFFF, 8'hFF, "R6"); rd("R6");
    wr('0, 8'h10, "R6"); wr(19'h0_0ABC, 8'hD0, "R6"); rd("R6");
    // R11: unknown code ignored
    wr('0, 8'hFF, "R11"); wr('0, 8'h3C, "R11"); rd("R11");
    // random mix
    for (int i = 0; i < 600; i++) begin
      int op;
      op = $urandom_range(0, 11);
      if (op < 6) begin
        logic [7:0] c;
        c = codes[$urandom_range(0, 9)];
        if (c == 8'h00) c = 8'($urandom);
        wr(ADDR_W'($urandom), c, "R12");
      end else if (op < 9) rd("R4");
      else if (op == 9) pulse($urandom_range(0, 2));
      else if (op == 10) pulse(2);
      else begin wsm_busy = ~wsm_busy; @(posedge clk); #1; end
    end
    finish_run();
  end

endmodule